// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the architectural-to-physical mapping used by an out-of-order core's rename stage. Architectural registers share one unified index space made of five consecutive ranges: integer (0-7), float (8-15), condition code (16-19), vector (20-23) and miscellaneous (24-27). The block decodes an index into its class and its index within that class. The first four classes each have their own map table. Each table covers its own contiguous slice of the physical tag space: integer tags 0-15, float tags 16-31, condition-code tags 32-39 and vector tags 40-47. Miscellaneous registers are not renamed.

A source lookup returns the current tag with no clock delay. A destination rename takes the head tag offered by that class's free list, asserts that class's pop strobe and returns both the new tag and the tag it displaces, so that later stages can release or forward the old one. A set-entry port writes mappings directly, which is how mappings are restored on commit or squash. A separate group check compares the per-class destination demands of an instruction group against the per-class free counts. The rename stage stalls the group unless every demand fits.

Top module: `rnm_table`

## Requirements
- R1: After reset, architectural register r of a renamed class maps to that class's first physical tag plus r. The first tags are integer 0, float 16, condition code 32 and vector 40, so for example unified index 10 reads tag 18 and index 21 reads tag 41.
- R2: `lk_tag` shows the current mapping of `lk_idx` in the same cycle, with no register on the path.
- R3: A valid rename of a non-zero register behaves as follows. `rn_new_tag` equals `fl_head` of its class. `rn_prev_tag` equals the old mapping. Only that class's bit of `fl_pop` is set (bit 0 integer, 1 float, 2 condition code, 3 vector). A lookup of the same register in that cycle still returns the old tag, and the new tag is visible from the next cycle.
- R4: Integer index 0 and float index 8 are fixed zero registers. A rename of either returns its fixed tag (0 or 16) as both new and previous tag and sets no `fl_pop` bit. Set-entry writes to them have no effect.
- R5: For miscellaneous indices (24-27), a lookup returns the index minus 24. A rename returns that value as both new and previous tag with no `fl_pop` bit. Set-entry writes change no mapping.
- R6: A set-entry write binds `se_tag` to the register from the next cycle. When it targets the same entry as a rename in the same cycle, the set-entry value is the one kept. When it targets a different entry, both writes take effect.
- R7: `admit` is 1 exactly when each of the four `need_cnt` fields is no larger than the matching `free_cnt` field (field k is at bits k of the packed arrays, in the class order of R3).
- R8: Every tag written into a class table, and every previous tag returned, lies in that class's physical range. A violation fires an assertion.
- R9: The condition-code and vector classes have no zero register: renaming index 16 or 20 allocates a tag like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the initial binding |
| lk_idx | input | 5 | Unified index of a source lookup |
| lk_tag | output | 6 | Mapped tag of `lk_idx` |
| rn_valid | input | 1 | Destination rename request |
| rn_idx | input | 5 | Unified index being renamed |
| rn_new_tag | output | 6 | Tag now assigned to the destination |
| rn_prev_tag | output | 6 | Tag the destination held before |
| fl_head | input | 4x6 | Next free tag offered by each class free list |
| fl_pop | output | 4 | Per-class pop strobe to the free lists |
| se_valid | input | 1 | Direct mapping write |
| se_idx | input | 5 | Unified index written |
| se_tag | input | 6 | Tag written |
| need_cnt | input | 4x3 | Destination demand of a group, per class |
| free_cnt | input | 4x7 | Free tags available, per class |
| admit | output | 1 | Group fits in every class |

## Verification
The bench keeps its own model of the mappings and targets the class boundaries (8, 16, 20, 24). A decoder that is off by one there would read the wrong table or rename a miscellaneous register. It renames both zero registers and the first condition-code and vector registers. A design that applied the zero rule to every class, or to none, would pop or fail to pop the free list there. It drives a rename and a set-entry to the same entry in one cycle, where the wrong priority leaves the free-list tag in place. It also looks up a register in the cycle it is renamed, where a bypassing design would return the new tag too early. Admission is tried at exact equality and with a single class over its limit, which exposes a strict comparison or a check that skips one class.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    localparam int NCLS = 4;

    typedef enum logic [2:0] {
        RC_INT  = 3'd0,
        RC_FP   = 3'd1,
        RC_CC   = 3'd2,
        RC_VEC  = 3'd3,
        RC_MISC = 3'd4
    } rclass_e;
endpackage

// File: rtl/rnm_decode.sv
module rnm_decode import rnm_pkg::*; #(
    parameter int INT_ARCH = 8,
    parameter int FP_ARCH  = 8,
    parameter int CC_ARCH  = 4,
    parameter int VEC_ARCH = 4,
    parameter int IDX_W    = 5
) (
    input  logic [IDX_W-1:0] idx,
    output rclass_e          cls,
    output logic [IDX_W-1:0] rel
);
    localparam logic [IDX_W-1:0] B_FP   = IDX_W'(INT_ARCH);
    localparam logic [IDX_W-1:0] B_CC   = IDX_W'(INT_ARCH + FP_ARCH);
    localparam logic [IDX_W-1:0] B_VEC  = IDX_W'(INT_ARCH + FP_ARCH + CC_ARCH);
    localparam logic [IDX_W-1:0] B_MISC = IDX_W'(INT_ARCH + FP_ARCH + CC_ARCH + VEC_ARCH);

    always_comb begin
        if (idx < B_FP) begin
            cls = RC_INT;
            rel = idx;
        end else if (idx < B_CC) begin
            cls = RC_FP;
            rel = idx - B_FP;
        end else if (idx < B_VEC) begin
            cls = RC_CC;
            rel = idx - B_CC;
        end else if (idx < B_MISC) begin
            cls = RC_VEC;
            rel = idx - B_VEC;
        end else begin
            cls = RC_MISC;
            rel = idx - B_MISC;
        end
    end
endmodule

// File: rtl/rnm_class_map.sv
module rnm_class_map #(
    parameter int NARCH    = 8,
    parameter int NPHYS    = 16,
    parameter int PBASE    = 0,
    parameter bit HAS_ZERO = 1'b1,
    parameter int TAG_W    = 6,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_rel,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             rn_en,
    input  logic [IDX_W-1:0] rn_rel,
    input  logic [TAG_W-1:0] rn_tag,
    output logic [TAG_W-1:0] rn_old,
    input  logic             se_en,
    input  logic [IDX_W-1:0] se_rel,
    input  logic [TAG_W-1:0] se_tag
);
    localparam int RW = (NARCH > 1) ? $clog2(NARCH) : 1;

    typedef struct packed {
        logic [NARCH-1:0][TAG_W-1:0] map;
    } map_st_t;

    map_st_t st_d, st_q;
    logic    rn_zero, se_zero;

    assign rn_zero = HAS_ZERO && (rn_rel == '0);
    assign se_zero = HAS_ZERO && (se_rel == '0);

    generate
        if (RW < IDX_W) begin : g_hi
            logic unused_rd_hi;
            assign unused_rd_hi = ^rd_rel[IDX_W-1:RW];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rn_en && !rn_zero)
            st_d.map[rn_rel[RW-1:0]] = rn_tag;
        // set-entry is applied last so it wins on a shared entry
        if (se_en && !se_zero)
            st_d.map[se_rel[RW-1:0]] = se_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++)
                st_q.map[i] <= TAG_W'(PBASE + i);
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tag = st_q.map[rd_rel[RW-1:0]];
    assign rn_old = st_q.map[rn_rel[RW-1:0]];

    // R3: a rename with no competing write lands in the table
    p_rename_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_en && !rn_zero && !(se_en && se_rel == rn_rel))
        |=> st_q.map[$past(rn_rel[RW-1:0])] == $past(rn_tag));

    // R6: set-entry value is what the table holds next cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (se_en && !se_zero) |=> st_q.map[$past(se_rel[RW-1:0])] == $past(se_tag));

    // R5: with no write request to this class the table holds still
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rn_en && !se_en) |=> $stable(st_q));

    // R8: every tag written and every previous tag is inside the class range
    p_rn_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_en && !rn_zero) |-> (int'(rn_tag) >= PBASE && int'(rn_tag) < PBASE + NPHYS));
    p_se_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (se_en && !se_zero) |-> (int'(se_tag) >= PBASE && int'(se_tag) < PBASE + NPHYS));
    p_old_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rn_en |-> (int'(rn_old) >= PBASE && int'(rn_old) < PBASE + NPHYS));
endmodule

// File: rtl/rnm_admit.sv
module rnm_admit #(
    parameter int NCLS  = 4,
    parameter int DEM_W = 3,
    parameter int CNT_W = 7
) (
    input  logic [NCLS-1:0][DEM_W-1:0] need_cnt,
    input  logic [NCLS-1:0][CNT_W-1:0] free_cnt,
    output logic                       admit
);
    logic [NCLS-1:0] fits;

    generate
        for (genvar g = 0; g < NCLS; g++) begin : g_cls
            assign fits[g] = CNT_W'(need_cnt[g]) <= free_cnt[g];
        end
    endgenerate

    assign admit = &fits;
endmodule

// File: rtl/rnm_table.sv
module rnm_table import rnm_pkg::*; #(
    parameter int INT_ARCH  = 8,
    parameter int FP_ARCH   = 8,
    parameter int CC_ARCH   = 4,
    parameter int VEC_ARCH  = 4,
    parameter int MISC_ARCH = 4,
    parameter int INT_PHYS  = 16,
    parameter int FP_PHYS   = 16,
    parameter int CC_PHYS   = 8,
    parameter int VEC_PHYS  = 8,
    parameter int DEM_W     = 3,
    localparam int ARCH_TOTAL = INT_ARCH + FP_ARCH + CC_ARCH + VEC_ARCH + MISC_ARCH,
    localparam int IDX_W      = $clog2(ARCH_TOTAL),
    localparam int PHYS_TOTAL = INT_PHYS + FP_PHYS + CC_PHYS + VEC_PHYS,
    localparam int TAG_W      = $clog2(PHYS_TOTAL),
    localparam int CNT_W      = TAG_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           lk_idx,
    output logic [TAG_W-1:0]           lk_tag,
    input  logic                       rn_valid,
    input  logic [IDX_W-1:0]           rn_idx,
    output logic [TAG_W-1:0]           rn_new_tag,
    output logic [TAG_W-1:0]           rn_prev_tag,
    input  logic [NCLS-1:0][TAG_W-1:0] fl_head,
    output logic [NCLS-1:0]            fl_pop,
    input  logic                       se_valid,
    input  logic [IDX_W-1:0]           se_idx,
    input  logic [TAG_W-1:0]           se_tag,
    input  logic [NCLS-1:0][DEM_W-1:0] need_cnt,
    input  logic [NCLS-1:0][CNT_W-1:0] free_cnt,
    output logic                       admit
);
    localparam logic [NCLS-1:0][31:0] ARCH_N =
        {32'(VEC_ARCH), 32'(CC_ARCH), 32'(FP_ARCH), 32'(INT_ARCH)};
    localparam logic [NCLS-1:0][31:0] PHYS_N =
        {32'(VEC_PHYS), 32'(CC_PHYS), 32'(FP_PHYS), 32'(INT_PHYS)};
    localparam logic [NCLS-1:0][31:0] PBASE_N =
        {32'(INT_PHYS + FP_PHYS + CC_PHYS), 32'(INT_PHYS + FP_PHYS), 32'(INT_PHYS), 32'd0};

    rclass_e          lk_cls, rn_cls, se_cls;
    logic [IDX_W-1:0] lk_rel, rn_rel, se_rel;
    logic [NCLS-1:0][TAG_W-1:0] rd_tags, old_tags;
    logic             rn_zero;

    rnm_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .CC_ARCH(CC_ARCH),
                 .VEC_ARCH(VEC_ARCH), .IDX_W(IDX_W))
        u_dec_lk (.idx(lk_idx), .cls(lk_cls), .rel(lk_rel));
    rnm_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .CC_ARCH(CC_ARCH),
                 .VEC_ARCH(VEC_ARCH), .IDX_W(IDX_W))
        u_dec_rn (.idx(rn_idx), .cls(rn_cls), .rel(rn_rel));
    rnm_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .CC_ARCH(CC_ARCH),
                 .VEC_ARCH(VEC_ARCH), .IDX_W(IDX_W))
        u_dec_se (.idx(se_idx), .cls(se_cls), .rel(se_rel));

    generate
        for (genvar g = 0; g < NCLS; g++) begin : g_map
            logic rn_hit, se_hit;
            assign rn_hit = rn_valid && (int'(rn_cls) == g);
            assign se_hit = se_valid && (int'(se_cls) == g);

            rnm_class_map #(
                .NARCH   (int'(ARCH_N[g])),
                .NPHYS   (int'(PHYS_N[g])),
                .PBASE   (int'(PBASE_N[g])),
                .HAS_ZERO(g < 2),
                .TAG_W   (TAG_W),
                .IDX_W   (IDX_W)
            ) u_map (
                .clk   (clk),
                .rst_n (rst_n),
                .rd_rel(lk_rel),
                .rd_tag(rd_tags[g]),
                .rn_en (rn_hit),
                .rn_rel(rn_rel),
                .rn_tag(fl_head[g]),
                .rn_old(old_tags[g]),
                .se_en (se_hit),
                .se_rel(se_rel),
                .se_tag(se_tag)
            );
        end
    endgenerate

    assign rn_zero = (rn_cls == RC_INT || rn_cls == RC_FP) && (rn_rel == '0);

    always_comb begin
        if (lk_cls == RC_MISC) lk_tag = TAG_W'(lk_rel);
        else                   lk_tag = rd_tags[lk_cls[1:0]];
    end

    always_comb begin
        fl_pop = '0;
        if (rn_cls == RC_MISC) begin
            rn_new_tag  = TAG_W'(rn_rel);
            rn_prev_tag = TAG_W'(rn_rel);
        end else begin
            rn_prev_tag = old_tags[rn_cls[1:0]];
            rn_new_tag  = rn_zero ? old_tags[rn_cls[1:0]] : fl_head[rn_cls[1:0]];
            fl_pop[rn_cls[1:0]] = rn_valid && !rn_zero;
        end
    end

    rnm_admit #(.NCLS(NCLS), .DEM_W(DEM_W), .CNT_W(CNT_W))
        u_admit (.need_cnt(need_cnt), .free_cnt(free_cnt), .admit(admit));

    // R3: at most one free list is popped per cycle
    p_one_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_pop));

    // R5: no free list is popped without a rename request
    p_pop_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rn_valid |-> (fl_pop == '0));
endmodule

// File: tb/rnm_table_test.sv
module rnm_table_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] lk_idx, rn_idx, se_idx;
    logic [5:0] lk_tag, rn_new_tag, rn_prev_tag, se_tag;
    logic       rn_valid, se_valid, admit;
    logic [3:0][5:0] fl_head;
    logic [3:0]      fl_pop;
    logic [3:0][2:0] need_cnt;
    logic [3:0][6:0] free_cnt;

    always #2 clk = ~clk;

    rnm_table uut (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag),
        .rn_valid(rn_valid), .rn_idx(rn_idx),
        .rn_new_tag(rn_new_tag), .rn_prev_tag(rn_prev_tag),
        .fl_head(fl_head), .fl_pop(fl_pop),
        .se_valid(se_valid), .se_idx(se_idx), .se_tag(se_tag),
        .need_cnt(need_cnt), .free_cnt(free_cnt), .admit(admit)
    );

    typedef struct {
        string req;
        int    sel;
        int    exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    mdl [24];

    function automatic int cls_of(int u);
        if (u < 8) return 0;
        if (u < 16) return 1;
        if (u < 20) return 2;
        if (u < 24) return 3;
        return 4;
    endfunction

    function automatic int abase(int c);
        case (c) 0: return 0; 1: return 8; 2: return 16; 3: return 20; default: return 24; endcase
    endfunction

    function automatic int pbase(int c);
        case (c) 0: return 0; 1: return 16; 2: return 32; default: return 40; endcase
    endfunction

    function automatic bit is_zero(int u);
        return (u == 0) || (u == 8);
    endfunction

    function automatic int exp_look(int u);
        if (cls_of(u) == 4) return u - 24;
        return mdl[u];
    endfunction

    function automatic int pick(int sel);
        case (sel)
            0: return int'(lk_tag);
            1: return int'(rn_new_tag);
            2: return int'(rn_prev_tag);
            3: return int'(fl_pop);
            default: return int'(admit);
        endcase
    endfunction

    task automatic push(string r, int sel, int e);
        item_t it;
        it.req = r; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    // monitor: compares after the driver has set inputs, before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                act = pick(it.sel);
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual %0d expected %0d", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic clr();
        rn_valid = 1'b0; se_valid = 1'b0;
        rn_idx = '0; se_idx = '0; se_tag = '0;
        fl_head = {6'd40, 6'd32, 6'd16, 6'd0};
        need_cnt = '0; free_cnt = '0;
    endtask

    task automatic t_look(int u, string r);
        @(negedge clk);
        clr();
        lk_idx = 5'(u);
        push(r, 0, exp_look(u));
    endtask

    task automatic t_ren(int u, int head, int lku, string r);
        int c;
        @(negedge clk);
        clr();
        c = cls_of(u);
        rn_valid = 1'b1; rn_idx = 5'(u); lk_idx = 5'(lku);
        if (c < 4) fl_head[c] = 6'(head);
        push(r, 0, exp_look(lku));
        if (c == 4) begin
            push(r, 1, u - 24); push(r, 2, u - 24); push(r, 3, 0);
        end else if (is_zero(u)) begin
            push(r, 1, mdl[u]); push(r, 2, mdl[u]); push(r, 3, 0);
        end else begin
            push(r, 1, head); push(r, 2, mdl[u]); push(r, 3, 1 << c);
            mdl[u] = head;
        end
    endtask

    task automatic t_set(int u, int tag, string r);
        @(negedge clk);
        clr();
        se_valid = 1'b1; se_idx = 5'(u); se_tag = 6'(tag); lk_idx = 5'(u);
        push(r, 0, exp_look(u));
        if (cls_of(u) < 4 && !is_zero(u)) mdl[u] = tag;
    endtask

    task automatic t_both(int ru, int head, int su, int stag, string r);
        int c;
        @(negedge clk);
        clr();
        c = cls_of(ru);
        rn_valid = 1'b1; rn_idx = 5'(ru); fl_head[c] = 6'(head);
        se_valid = 1'b1; se_idx = 5'(su); se_tag = 6'(stag);
        lk_idx = 5'(ru);
        push(r, 1, head); push(r, 2, mdl[ru]); push(r, 3, 1 << c);
        mdl[ru] = head;
        mdl[su] = stag;
    endtask

    task automatic t_adm(logic [3:0][2:0] nd, logic [3:0][6:0] fr, int e, string r);
        @(negedge clk);
        clr();
        need_cnt = nd; free_cnt = fr;
        push(r, 4, e);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clr();
        lk_idx = '0;
        for (int u = 0; u < 24; u++) mdl[u] = pbase(cls_of(u)) + u - abase(cls_of(u));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset binding for every renamed register, R5 misc lookup
        for (int u = 0; u < 24; u++) t_look(u, "R1 reset map");
        t_look(24, "R5 misc lookup");
        t_look(27, "R5 misc lookup");

        // R3 rename with same-cycle lookup of the old tag, R2 next-cycle view
        t_ren(3, 9, 3, "R3 int rename");
        t_look(3, "R2 lookup after rename");
        t_ren(10, 20, 7, "R3 fp rename");
        t_look(10, "R2 lookup after fp rename");
        t_ren(3, 12, 3, "R3 second rename");
        t_look(3, "R2 lookup after second rename");

        // R9 no zero register in condition-code and vector classes
        t_ren(16, 37, 16, "R9 cc index 0 rename");
        t_look(16, "R9 cc lookup");
        t_ren(20, 47, 20, "R9 vec index 0 rename");
        t_ren(23, 44, 22, "R3 vec rename");
        t_look(23, "R2 vec lookup");

        // R4 zero registers
        t_ren(0, 5, 0, "R4 int zero rename");
        t_look(0, "R4 int zero kept");
        t_ren(8, 25, 8, "R4 fp zero rename");
        t_look(8, "R4 fp zero kept");
        t_set(0, 7, "R4 int zero set");
        t_look(0, "R4 int zero set ignored");
        t_set(8, 30, "R4 fp zero set");
        t_look(8, "R4 fp zero set ignored");

        // R5 misc rename and set-entry
        t_ren(26, 11, 26, "R5 misc rename");
        t_set(25, 3, "R5 misc set");
        t_look(25, "R5 misc set ignored");

        // R6 set-entry and priority
        t_set(5, 14, "R6 set int");
        t_look(5, "R6 set visible");
        t_set(19, 38, "R6 set cc");
        t_look(19, "R6 set cc visible");
        t_both(6, 13, 6, 15, "R6 same entry");
        t_look(6, "R6 set wins");
        t_both(1, 11, 2, 10, "R6 different entries");
        t_look(1, "R6 rename kept");
        t_look(2, "R6 set kept");

        // R7 admission
        t_adm({3'd2, 3'd3, 3'd1, 3'd4}, {7'd2, 7'd3, 7'd1, 7'd4}, 1, "R7 equal counts");
        t_adm({3'd0, 3'd0, 3'd0, 3'd5}, {7'd9, 7'd9, 7'd9, 7'd4}, 0, "R7 int over");
        t_adm({3'd3, 3'd0, 3'd0, 3'd0}, {7'd2, 7'd9, 7'd9, 7'd9}, 0, "R7 vec over");
        t_adm({3'd0, 3'd1, 3'd0, 3'd0}, {7'd9, 7'd0, 7'd9, 7'd9}, 0, "R7 cc over");
        t_adm('0, '0, 1, "R7 no demand");
        t_adm({3'd7, 3'd7, 3'd7, 3'd7}, {7'd64, 7'd8, 7'd7, 7'd100}, 1, "R7 large free");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule